// File: doc/BRIEF.md
# Interrupt Reason and Transfer Enable Logic

This block sits beside the packet FIFO, the host bus engine and the sector decoder of a packet-command storage drive controller. It keeps three active-low interrupt flags, one each for packet FIFO occupancy, transfer completion and sector/status attention. It also keeps the transfer-enable level that gates the data transfer logic. Every input is a single-cycle event strobe or a qualifier that is sampled with one, so the block is a small set of flags that event strobes set and release.

The local processor sets the per-flag interrupt enables and the sector flag mode by writing a configuration byte. It releases flags through side effects: it reads the last FIFO byte, reads one of three status registers, or writes the two acknowledge registers. When a transfer ends, the transfer-end flag latches qualifiers that tell a data-in end, a data-out end and a command-packet end apart. The transfer-enable level is written by the processor. It also sets itself on an automatic-transfer trigger, and on a packet command from the host when packet handling is on and the drive is selected.

Top module: `irq_reason_ctl`

## Requirements
- R1: After reset, `flags_n` reads 8'hFF, `irq_n` is 1, `xfer_en` is 0, `end_data` and `end_in` are 0, and all interrupt enables and the sector mode bit are 0.
- R2: A cycle with `xen_wr` high loads `xen_wdata` into `xfer_en` at the next edge. A write of 0 drops `xfer_en` in that one cycle.
- R3: `xfer_en` becomes 1 after a cycle with `auto_trig`, or with `pkt_cmd` while both `pkt_mode_en` and `drv_sel` are high. A `pkt_cmd` without both of these has no effect. A self-set wins over a write of 0 in the same cycle.
- R4: Flag bit 7 (FIFO holds packet bytes) goes 0 after `pkt_byte_wr` and returns to 1 after `pkt_last_rd`. If both strobes come in the same cycle, the bit goes 0.
- R5: Flag bit 6 (transfer ended) goes 0 after `xfer_end`. In the same edge, `end_data` latches `xfer_data` (1 = data transfer, 0 = command packet) and `end_in` latches `xfer_in` (1 = toward the host). Both hold until the next `xfer_end`.
- R6: For an end with `end_data`=0, or with `end_in`=0, `gen_ack_wr` alone returns bit 6 to 1. For a data-in end (`end_data`=1 and `end_in`=1), `gen_ack_wr` returns it to 1 only if `din_ack_wr` came after that end or comes in the same cycle. An `xfer_end` in the same cycle as `gen_ack_wr` keeps the bit at 0.
- R7: Flag bit 5 (sector/status attention) goes 0 after `sec_rdy` while the mode bit is 0. While the mode bit is 1 it goes 0 after any bit of `stat_ev`, and `sec_rdy` is ignored. The source is chosen by the mode value held before the cycle.
- R8: Any bit of `stat_rd` returns flag bit 5 to 1. If a set source for the bit is active in the same cycle, the bit goes 0.
- R9: A `cfg_wr` loads `cfg_wdata`: bit 7 enables flag 7, bit 6 enables flag 6, bit 5 enables flag 5, and bit 0 is the sector mode. Flag bits 4 to 0 always read 1. `irq_n` is 0 exactly while some enabled flag is 0. With the default `IRQ_REG`=0, `irq_n` follows the flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_byte_wr | input | 1 | Host wrote a byte into the packet FIFO |
| pkt_last_rd | input | 1 | Processor read the last packet FIFO byte |
| xfer_end | input | 1 | A transfer finished |
| xfer_data | input | 1 | Qualifier with xfer_end: 1 data transfer, 0 command packet |
| xfer_in | input | 1 | Qualifier with xfer_end: 1 data toward host |
| gen_ack_wr | input | 1 | Write to the general transfer acknowledge |
| din_ack_wr | input | 1 | Write to the data-in acknowledge |
| sec_rdy | input | 1 | A sector is available |
| stat_ev | input | NUM_STAT_EV | Status and error events |
| stat_rd | input | NUM_CLR_RD | Reads of the status registers that release the sector flag |
| auto_trig | input | 1 | Processor triggered an automatic transfer |
| pkt_cmd | input | 1 | Host issued a packet command |
| pkt_mode_en | input | 1 | Packet command handling enabled |
| drv_sel | input | 1 | This drive is selected |
| xen_wr | input | 1 | Processor write of the transfer-enable bit |
| xen_wdata | input | 1 | Value written to transfer enable |
| cfg_wr | input | 1 | Processor write of the configuration byte |
| cfg_wdata | input | 8 | Configuration byte value |
| irq_n | output | 1 | Interrupt pin, active low |
| flags_n | output | 8 | Readable flag byte, flags active low |
| end_data | output | 1 | Latched data/packet qualifier of the last end |
| end_in | output | 1 | Latched direction qualifier of the last end |
| xfer_en | output | 1 | Transfer enable level |

## Verification
The hardest state to reach is a data-in end that is only half acknowledged. This needs a data-in qualifier pair, then a general acknowledge with no data-in acknowledge since that end, then a later data-in acknowledge, all without an intervening new end. Directed sequences build that order, and also the same-cycle collisions between set and release strobes. A seeded random phase then fires strobes with low, independent probabilities, so that ends, acknowledges and collisions interleave in many orders. A bench model predicts every output in every cycle.

// File: rtl/irq_reason_pkg.sv
package irq_reason_pkg;
   localparam int FLAG_W   = 8;
   localparam int BIT_PFNE = 7;
   localparam int BIT_TEND = 6;
   localparam int BIT_SRI  = 5;
   localparam int CFG_MODE = 0;

   typedef struct packed {
      logic pfne_en;
      logic tend_en;
      logic sri_en;
      logic sri_mode;
   } irq_cfg_t;
endpackage

// File: rtl/irq_rsn_flag.sv
// Active-low flag: a set event drives it low and a release event drives it
// high. When both come in one cycle, the set wins.
module irq_rsn_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr_ev,
   output logic flag_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_n <= 1'b1;
      else if (set_ev) flag_n <= 1'b0;
      else if (clr_ev) flag_n <= 1'b1;
   end
endmodule

// File: rtl/irq_rsn_tend.sv
// Transfer-end flag with latched qualifiers and the two-step data-in acknowledge.
module irq_rsn_tend (
   input  logic clk,
   input  logic rst_n,
   input  logic xfer_end,
   input  logic xfer_data,
   input  logic xfer_in,
   input  logic gen_ack_wr,
   input  logic din_ack_wr,
   output logic tend_n,
   output logic q_data,
   output logic q_in
);
   logic din_seen;
   logic need_din;
   logic release_ok;

   assign need_din   = q_data & q_in;
   assign release_ok = gen_ack_wr & (~need_din | din_seen | din_ack_wr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tend_n   <= 1'b1;
         q_data   <= 1'b0;
         q_in     <= 1'b0;
         din_seen <= 1'b0;
      end else if (xfer_end) begin
         tend_n   <= 1'b0;
         q_data   <= xfer_data;
         q_in     <= xfer_in;
         din_seen <= 1'b0;
      end else begin
         din_seen <= din_seen | din_ack_wr;
         if (release_ok) tend_n <= 1'b1;
      end
   end
endmodule

// File: rtl/irq_rsn_xen.sv
// Transfer-enable level: processor write plus two self-set triggers.
module irq_rsn_xen (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_trig,
   input  logic pkt_cmd,
   input  logic pkt_mode_en,
   input  logic drv_sel,
   input  logic xen_wr,
   input  logic xen_wdata,
   output logic xfer_en
);
   logic self_set;
   assign self_set = auto_trig | (pkt_cmd & pkt_mode_en & drv_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        xfer_en <= 1'b0;
      else if (self_set) xfer_en <= 1'b1;
      else if (xen_wr)   xfer_en <= xen_wdata;
   end
endmodule

// File: rtl/irq_reason_ctl.sv
module irq_reason_ctl
   import irq_reason_pkg::*;
#(
   parameter int NUM_STAT_EV = 7,
   parameter int NUM_CLR_RD  = 3,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pkt_byte_wr,
   input  logic                   pkt_last_rd,
   input  logic                   xfer_end,
   input  logic                   xfer_data,
   input  logic                   xfer_in,
   input  logic                   gen_ack_wr,
   input  logic                   din_ack_wr,
   input  logic                   sec_rdy,
   input  logic [NUM_STAT_EV-1:0] stat_ev,
   input  logic [NUM_CLR_RD-1:0]  stat_rd,
   input  logic                   auto_trig,
   input  logic                   pkt_cmd,
   input  logic                   pkt_mode_en,
   input  logic                   drv_sel,
   input  logic                   xen_wr,
   input  logic                   xen_wdata,
   input  logic                   cfg_wr,
   input  logic [FLAG_W-1:0]      cfg_wdata,
   output logic                   irq_n,
   output logic [FLAG_W-1:0]      flags_n,
   output logic                   end_data,
   output logic                   end_in,
   output logic                   xfer_en
);
   localparam int NUM_FLAGS = 3;

   if (NUM_STAT_EV < 1) begin : g_bad_ev
      $error("NUM_STAT_EV must be at least 1");
   end
   if (NUM_CLR_RD < 1) begin : g_bad_rd
      $error("NUM_CLR_RD must be at least 1");
   end

   irq_cfg_t cfg_q;
   logic pf_n, te_n, sr_n;
   logic sri_set;
   logic [NUM_FLAGS-1:0] act_vec;
   logic [NUM_FLAGS-1:0] en_vec;
   logic pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else if (cfg_wr) begin
         cfg_q.pfne_en  <= cfg_wdata[BIT_PFNE];
         cfg_q.tend_en  <= cfg_wdata[BIT_TEND];
         cfg_q.sri_en   <= cfg_wdata[BIT_SRI];
         cfg_q.sri_mode <= cfg_wdata[CFG_MODE];
      end
   end

   assign sri_set = cfg_q.sri_mode ? (|stat_ev) : sec_rdy;

   irq_rsn_flag u_pfne (
      .clk(clk), .rst_n(rst_n),
      .set_ev(pkt_byte_wr), .clr_ev(pkt_last_rd), .flag_n(pf_n)
   );

   irq_rsn_flag u_sri (
      .clk(clk), .rst_n(rst_n),
      .set_ev(sri_set), .clr_ev(|stat_rd), .flag_n(sr_n)
   );

   irq_rsn_tend u_tend (
      .clk(clk), .rst_n(rst_n),
      .xfer_end(xfer_end), .xfer_data(xfer_data), .xfer_in(xfer_in),
      .gen_ack_wr(gen_ack_wr), .din_ack_wr(din_ack_wr),
      .tend_n(te_n), .q_data(end_data), .q_in(end_in)
   );

   irq_rsn_xen u_xen (
      .clk(clk), .rst_n(rst_n),
      .auto_trig(auto_trig), .pkt_cmd(pkt_cmd), .pkt_mode_en(pkt_mode_en),
      .drv_sel(drv_sel), .xen_wr(xen_wr), .xen_wdata(xen_wdata),
      .xfer_en(xfer_en)
   );

   always_comb begin
      flags_n           = '1;
      flags_n[BIT_PFNE] = pf_n;
      flags_n[BIT_TEND] = te_n;
      flags_n[BIT_SRI]  = sr_n;
   end

   assign act_vec = {~pf_n, ~te_n, ~sr_n};
   assign en_vec  = {cfg_q.pfne_en, cfg_q.tend_en, cfg_q.sri_en};
   assign pend    = |(act_vec & en_vec);

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_n <= 1'b1;
         else        irq_n <= ~pend;
      end
   end else begin : g_irq_comb
      assign irq_n = ~pend;
   end
endmodule

// File: rtl/irq_reason_chk.sv
module irq_reason_chk #(
   parameter int NUM_STAT_EV = 7,
   parameter int NUM_CLR_RD  = 3,
   parameter bit IRQ_REG     = 1'b0
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   pkt_byte_wr,
   input logic                   xfer_end,
   input logic                   xfer_data,
   input logic                   xfer_in,
   input logic                   gen_ack_wr,
   input logic                   sec_rdy,
   input logic [NUM_STAT_EV-1:0] stat_ev,
   input logic [NUM_CLR_RD-1:0]  stat_rd,
   input logic                   auto_trig,
   input logic                   pkt_cmd,
   input logic                   pkt_mode_en,
   input logic                   drv_sel,
   input logic                   xen_wr,
   input logic                   xen_wdata,
   input logic                   irq_n,
   input logic [7:0]             flags_n,
   input logic                   end_data,
   input logic                   end_in,
   input logic                   xfer_en
);
   a_r1_leave_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (flags_n == 8'hFF && !xfer_en && irq_n));

   a_r2_write_low: assert property (@(posedge clk) disable iff (!rst_n)
      (xen_wr && !xen_wdata && !auto_trig && !(pkt_cmd && pkt_mode_en && drv_sel))
      |=> !xfer_en);

   a_r3_auto_set: assert property (@(posedge clk) disable iff (!rst_n)
      auto_trig |=> xfer_en);

   a_r3_pkt_set: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_cmd && pkt_mode_en && drv_sel) |=> xfer_en);

   a_r4_fifo_set: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_byte_wr |=> !flags_n[7]);

   a_r5_end_latch: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end |=> (!flags_n[6] && end_data == $past(xfer_data) && end_in == $past(xfer_in)));

   a_r6_hold_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags_n[6] && !gen_ack_wr) |=> !flags_n[6]);

   a_r8_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((|stat_rd) && !sec_rdy && !(|stat_ev)) |=> flags_n[5]);

   if (IRQ_REG) begin : g_q_reg
      a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (&flags_n) |=> irq_n);
   end else begin : g_q_comb
      a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (&flags_n) |-> irq_n);
   end
endmodule

bind irq_reason_ctl irq_reason_chk #(
   .NUM_STAT_EV(NUM_STAT_EV), .NUM_CLR_RD(NUM_CLR_RD), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pkt_byte_wr(pkt_byte_wr), .xfer_end(xfer_end),
   .xfer_data(xfer_data), .xfer_in(xfer_in), .gen_ack_wr(gen_ack_wr),
   .sec_rdy(sec_rdy), .stat_ev(stat_ev), .stat_rd(stat_rd),
   .auto_trig(auto_trig), .pkt_cmd(pkt_cmd), .pkt_mode_en(pkt_mode_en),
   .drv_sel(drv_sel), .xen_wr(xen_wr), .xen_wdata(xen_wdata),
   .irq_n(irq_n), .flags_n(flags_n), .end_data(end_data), .end_in(end_in),
   .xfer_en(xfer_en)
);

// File: tb/irq_reason_ctl_tb.sv
module irq_reason_ctl_tb;
   localparam int CLK_P = 10;
   localparam int NEV   = 7;
   localparam int NRD   = 3;

   logic clk = 1'b0;
   logic rst_n;
   logic pkt_byte_wr, pkt_last_rd, xfer_end, xfer_data, xfer_in;
   logic gen_ack_wr, din_ack_wr, sec_rdy;
   logic [NEV-1:0] stat_ev;
   logic [NRD-1:0] stat_rd;
   logic auto_trig, pkt_cmd, pkt_mode_en, drv_sel, xen_wr, xen_wdata, cfg_wr;
   logic [7:0] cfg_wdata;
   logic irq_n, end_data, end_in, xfer_en;
   logic [7:0] flags_n;

   irq_reason_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .pkt_byte_wr(pkt_byte_wr), .pkt_last_rd(pkt_last_rd),
      .xfer_end(xfer_end), .xfer_data(xfer_data), .xfer_in(xfer_in),
      .gen_ack_wr(gen_ack_wr), .din_ack_wr(din_ack_wr), .sec_rdy(sec_rdy),
      .stat_ev(stat_ev), .stat_rd(stat_rd), .auto_trig(auto_trig), .pkt_cmd(pkt_cmd),
      .pkt_mode_en(pkt_mode_en), .drv_sel(drv_sel), .xen_wr(xen_wr),
      .xen_wdata(xen_wdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .irq_n(irq_n), .flags_n(flags_n), .end_data(end_data), .end_in(end_in),
      .xfer_en(xfer_en)
   );

   always #(CLK_P/2) clk = ~clk;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   // bench model state
   bit m_pf, m_te, m_sr, m_seen, m_qd, m_qi, m_xen;
   bit m_e7, m_e6, m_e5, m_mode;

   function automatic bit exp_irq(bit pf, bit te, bit sr, bit e7, bit e6, bit e5);
      return !((!pf && e7) || (!te && e6) || (!sr && e5));
   endfunction

   function automatic logic [7:0] exp_flags(bit pf, bit te, bit sr);
      return {pf, te, sr, 5'b11111};
   endfunction

   task automatic model_reset();
      m_pf = 1; m_te = 1; m_sr = 1; m_seen = 0; m_qd = 0; m_qi = 0; m_xen = 0;
      m_e7 = 0; m_e6 = 0; m_e5 = 0; m_mode = 0;
   endtask

   task automatic model_step();
      bit sri_src, self_set, rel;
      if (!rst_n) begin model_reset(); return; end
      sri_src  = m_mode ? (|stat_ev) : sec_rdy;
      self_set = auto_trig || (pkt_cmd && pkt_mode_en && drv_sel);
      if (pkt_byte_wr) m_pf = 0; else if (pkt_last_rd) m_pf = 1;
      if (sri_src) m_sr = 0; else if (|stat_rd) m_sr = 1;
      if (xfer_end) begin
         m_te = 0; m_qd = xfer_data; m_qi = xfer_in; m_seen = 0;
      end else begin
         rel = gen_ack_wr && (!(m_qd && m_qi) || m_seen || din_ack_wr);
         if (din_ack_wr) m_seen = 1;
         if (rel) m_te = 1;
      end
      if (self_set) m_xen = 1; else if (xen_wr) m_xen = xen_wdata;
      if (cfg_wr) begin
         m_e7 = cfg_wdata[7]; m_e6 = cfg_wdata[6]; m_e5 = cfg_wdata[5]; m_mode = cfg_wdata[0];
      end
   endtask

   task automatic chk(bit ok, string req, string what, int got, int exp);
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic compare();
      logic [7:0] ef;
      ef = exp_flags(m_pf, m_te, m_sr);
      vectors++;
      chk(flags_n[7] === m_pf, "R4", "fifo flag", flags_n[7], m_pf);
      chk(flags_n[6] === m_te, "R6", "end flag", flags_n[6], m_te);
      chk(flags_n[5] === m_sr, "R7", "sector flag", flags_n[5], m_sr);
      chk(flags_n === ef, "R9", "flag byte", flags_n, ef);
      chk(end_data === m_qd && end_in === m_qi, "R5", "qualifiers",
          {end_data, end_in}, {m_qd, m_qi});
      chk(xfer_en === m_xen, "R3", "xfer_en", xfer_en, m_xen);
      chk(irq_n === exp_irq(m_pf, m_te, m_sr, m_e7, m_e6, m_e5), "R9", "irq_n",
          irq_n, exp_irq(m_pf, m_te, m_sr, m_e7, m_e6, m_e5));
   endtask

   task automatic idle();
      pkt_byte_wr = 0; pkt_last_rd = 0; xfer_end = 0; xfer_data = 0; xfer_in = 0;
      gen_ack_wr = 0; din_ack_wr = 0; sec_rdy = 0; stat_ev = '0; stat_rd = '0;
      auto_trig = 0; pkt_cmd = 0; pkt_mode_en = 0; drv_sel = 0; xen_wr = 0;
      xen_wdata = 0; cfg_wr = 0; cfg_wdata = '0;
   endtask

   // apply current inputs for one edge, then check at the falling edge
   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
      idle();
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1F2E_3D4C));
      rst_n = 0;
      idle();
      model_reset();
      repeat (3) @(negedge clk);
      vectors++;
      chk(flags_n === 8'hFF && irq_n === 1'b1 && xfer_en === 1'b0 &&
          end_data === 1'b0 && end_in === 1'b0, "R1", "reset state",
          {flags_n, irq_n, xfer_en, end_data, end_in}, {8'hFF, 4'b1000});
      rst_n = 1;
      cyc();

      // R2: write 1 then write 0
      xen_wr = 1; xen_wdata = 1; cyc();
      xen_wr = 1; xen_wdata = 0; cyc();
      vectors++; chk(xfer_en === 1'b0, "R2", "write low", xfer_en, 0);

      // R3: gated packet command ignored, then collision with write low
      pkt_cmd = 1; pkt_mode_en = 1; drv_sel = 0; cyc();
      vectors++; chk(xfer_en === 1'b0, "R3", "ungated pkt_cmd", xfer_en, 0);
      auto_trig = 1; xen_wr = 1; xen_wdata = 0; cyc();
      vectors++; chk(xfer_en === 1'b1, "R3", "set beats write low", xfer_en, 1);

      // R9: enable all, R4 collision
      cfg_wr = 1; cfg_wdata = 8'hE0; cyc();
      pkt_byte_wr = 1; pkt_last_rd = 1; cyc();
      vectors++; chk(flags_n[7] === 1'b0 && irq_n === 1'b0, "R4", "set wins",
                     {flags_n[7], irq_n}, 0);
      pkt_last_rd = 1; cyc();

      // R6: data-in end, general ack alone keeps it low
      xfer_end = 1; xfer_data = 1; xfer_in = 1; cyc();
      gen_ack_wr = 1; cyc();
      vectors++; chk(flags_n[6] === 1'b0, "R6", "half ack", flags_n[6], 0);
      din_ack_wr = 1; cyc();
      gen_ack_wr = 1; cyc();
      vectors++; chk(flags_n[6] === 1'b1, "R6", "full ack", flags_n[6], 1);
      vectors++; chk(end_data === 1'b1 && end_in === 1'b1, "R5", "quals held",
                     {end_data, end_in}, 2'b11);
      // data-out end released by general ack alone; ack with new end
      xfer_end = 1; xfer_data = 1; xfer_in = 0; cyc();
      gen_ack_wr = 1; xfer_end = 1; xfer_data = 0; cyc();
      vectors++; chk(flags_n[6] === 1'b0, "R6", "end beats ack", flags_n[6], 0);
      gen_ack_wr = 1; cyc();

      // R7: mode 1 ignores sec_rdy, R8 collision
      cfg_wr = 1; cfg_wdata = 8'hE1; cyc();
      sec_rdy = 1; cyc();
      vectors++; chk(flags_n[5] === 1'b1, "R7", "sec_rdy ignored", flags_n[5], 1);
      stat_ev = 7'b0001000; stat_rd = 3'b100; cyc();
      vectors++; chk(flags_n[5] === 1'b0, "R8", "set beats read", flags_n[5], 0);
      stat_rd = 3'b010; cyc();
      vectors++; chk(flags_n[5] === 1'b1, "R8", "read clears", flags_n[5], 1);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         pkt_byte_wr = ($urandom % 8) == 0;
         pkt_last_rd = ($urandom % 6) == 0;
         xfer_end    = ($urandom % 8) == 0;
         xfer_data   = $urandom % 2;
         xfer_in     = $urandom % 2;
         gen_ack_wr  = ($urandom % 5) == 0;
         din_ack_wr  = ($urandom % 6) == 0;
         sec_rdy     = ($urandom % 7) == 0;
         for (int b = 0; b < NEV; b++) stat_ev[b] = ($urandom % 40) == 0;
         for (int b = 0; b < NRD; b++) stat_rd[b] = ($urandom % 12) == 0;
         auto_trig   = ($urandom % 20) == 0;
         pkt_cmd     = ($urandom % 8) == 0;
         pkt_mode_en = $urandom % 2;
         drv_sel     = $urandom % 2;
         xen_wr      = ($urandom % 6) == 0;
         xen_wdata   = $urandom % 2;
         cfg_wr      = ($urandom % 30) == 0;
         cfg_wdata   = $urandom % 256;
         cyc();
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule